// File: doc/BRIEF.md
# Double-Buffered PWM Period Timer

This block is a 16-bit up-counting timer for pulse-width modulation and motor drive. A free-running counter advances on a count enable. The enable comes from an internal divider that fires once every 1, 2, 4 or 8 clock cycles. When the counter reaches the programmed period value, it returns to zero. Four compare registers are each checked against the counter every count step. Each one produces a single-cycle match pulse when its value equals the count.

Software reaches the period and compare registers through a simple register port that can write and read them. While the timer is stopped, a write changes the active value at once. While it runs, a write is parked in a hidden shadow copy. All parked values then take effect together, in the same cycle that the counter wraps to zero. This keeps a PWM period from ever seeing a half-updated set of thresholds.

The period register is always buffered while running. Each compare register has its own buffer-enable bit. In the power-switch drive mode, the first two compare registers are buffered no matter what their enable bits say.

Top module: `pwm_period_timer`

## Requirements
- R1: While running, each count step adds one to the counter. A step taken when the counter equals the period value clears it to zero, so a period value M gives a cycle of M+1 count steps.
- R2: Output bit i of `match_o` is high for exactly the clock cycle of a count step in which the counter equals compare register i. It is never high while `run_i` is low.
- R3: While `run_i` is low, the counter holds its value, and an accepted write updates the addressed active register on the next clock edge.
- R4: `rd_data_o` shows the active value of the register selected by `rd_addr_i`. Addresses 0 to 3 select compare registers 0 to 3, and address 4 selects the period register. Other addresses read zero. A shadow value is never visible.
- R5: While running, a buffered write is held in its shadow copy. It becomes active on the clock edge where the counter wraps to zero, together with all other buffered registers.
- R6: While running, a write to the period register (address 4) is always buffered.
- R7: While `power_mode_i` is high and the timer runs, writes to compare registers 0 and 1 are buffered, regardless of `buf_en_i`.
- R8: `wr_size_i` = 2'b00 marks a byte write. It is rejected and leaves every register unchanged. The codes 2'b01 (16-bit) and 2'b10 or 2'b11 (32-bit, low 16 bits used) are accepted.
- R9: `div_sel_i` values 0, 1, 2 and 3 give one count step every 1, 2, 4 and 8 clock cycles. The divider restarts whenever the timer is stopped, so the first step after starting comes N cycles after `run_i` rises.
- R10: After reset, the timer is stopped. The counter, all active registers and all shadow copies are zero, and no match is signalled.
- R11: While running, outside power mode, a compare register whose `buf_en_i` bit is 0 takes a write directly, on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_i | input | 1 | 1 = counter runs, 0 = stopped |
| div_sel_i | input | 2 | Count divider select: 1, 2, 4 or 8 cycles per step |
| power_mode_i | input | 1 | Power-switch drive mode; forces buffering of compare 0 and 1 |
| buf_en_i | input | 4 | Per-compare buffer enable while running |
| wr_en_i | input | 1 | Write strobe |
| wr_size_i | input | 2 | Access size code; 2'b00 (byte) is rejected |
| wr_addr_i | input | 3 | Write address: 0-3 compare, 4 period |
| wr_data_i | input | 16 | Write data |
| rd_addr_i | input | 3 | Read address |
| rd_data_o | output | 16 | Active value of the addressed register |
| count_o | output | 16 | Current counter value |
| match_o | output | 4 | Per-compare match pulse |
| period_match_o | output | 1 | Pulse on the count step that wraps the counter |

## Verification
The hardest case to reach is a buffered write that is still pending when the wrap happens. Its value has to be invisible on the read port right up to the wrap edge, and then appear in exactly the cycle the counter reads zero. The bench writes several registers while the counter runs, then reads them back at once to show the old values. It then walks the counter one cycle at a time to the period value. It checks the count and the read-back on the very next cycle, with a new period value, so that the length of the following cycle also shows which value took effect. The power mode and the divided count enable are driven through the same cycle-by-cycle walk.

// File: rtl/pwm_tmr_pkg.sv
// Package: shared encodings for the PWM period timer.
// Assumes: access size codes come from the register port unchanged.
package pwm_tmr_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'b00,
        SZ_HALF  = 2'b01,
        SZ_WORD  = 2'b10,
        SZ_WORDX = 2'b11
    } wr_size_e;

    // True when an access size is wide enough to be accepted.
    function automatic logic size_ok(input logic [1:0] sz);
        return sz != SZ_BYTE;
    endfunction

endpackage

// File: rtl/pwm_tick_gen.sv
// Module: pwm_tick_gen
// Produces a single-cycle count enable every 2**div_sel cycles while run is high.
// Assumes: the divider state is cleared whenever run is low, so the first
// enable after start arrives a full divide interval after run rises.
module pwm_tick_gen #(
    parameter int DIV_W = 2,
    localparam int PRE_W = (1 << DIV_W) - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div_sel,
    output logic             tick
);

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] mask;

    // Build the low-bit mask for the chosen ratio.
    always_comb begin
        for (int b = 0; b < PRE_W; b++) begin
            mask[b] = (b < int'(div_sel));
        end
    end

    // Enable fires when all masked divider bits are set.
    assign tick = run && ((pre_q & mask) == mask);

    // Advance the divider while running, clear it while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

endmodule

// File: rtl/pwm_up_counter.sv
// Module: pwm_up_counter
// Up-counter that clears to zero on the step where it equals the period.
// Assumes: tick already includes the run qualifier.
module pwm_up_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] count,
    output logic             wrap
);

    // Wrap is the count step taken at the period value.
    assign wrap = tick && (count == period);

    // Step or clear the counter on each enabled cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (wrap) begin
            count <= '0;
        end else if (tick) begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/pwm_shadow_regs.sv
// Module: pwm_shadow_regs
// Active and shadow copies of the compare registers plus the period register.
// Every accepted write refreshes the shadow copy. The active copy takes the
// write at once unless the register is in buffered mode, in which case it
// loads from the shadow copy on the wrap step.
// Assumes: address N_CMP is the period register; 0..N_CMP-1 are compares.
module pwm_shadow_regs #(
    parameter int CNT_W   = 16,
    parameter int N_CMP   = 4,
    parameter int PM_REGS = 2,
    parameter int ADDR_W  = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        run,
    input  logic                        power_mode,
    input  logic [N_CMP-1:0]            buf_en,
    input  logic                        wr_en,
    input  logic [1:0]                  wr_size,
    input  logic [ADDR_W-1:0]           wr_addr,
    input  logic [CNT_W-1:0]            wr_data,
    input  logic                        load,
    output logic [N_CMP-1:0][CNT_W-1:0] cmp_act,
    output logic [CNT_W-1:0]            per_act
);

    import pwm_tmr_pkg::*;

    localparam int N_REG = N_CMP + 1;

    logic [N_REG-1:0][CNT_W-1:0] act_q;
    logic [N_REG-1:0][CNT_W-1:0] shd_q;
    logic [N_REG-1:0]            buf_cfg;
    logic [N_REG-1:0]            wr_hit;

    for (genvar i = 0; i < N_REG; i++) begin : g_reg
        // Select the buffering policy for this register.
        if (i == N_CMP) begin : g_per
            assign buf_cfg[i] = 1'b1;
        end else if (i < PM_REGS) begin : g_pm
            assign buf_cfg[i] = power_mode || buf_en[i];
        end else begin : g_plain
            assign buf_cfg[i] = buf_en[i];
        end

        // Decode an accepted write to this register.
        assign wr_hit[i] = wr_en && size_ok(wr_size) && (wr_addr == ADDR_W'(i));

        // Refresh the shadow copy on every accepted write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                shd_q[i] <= '0;
            end else if (wr_hit[i]) begin
                shd_q[i] <= wr_data;
            end
        end

        // Update the active copy directly or from the shadow on wrap.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                act_q[i] <= '0;
            end else if (wr_hit[i] && !(run && buf_cfg[i])) begin
                act_q[i] <= wr_data;
            end else if (load && buf_cfg[i]) begin
                act_q[i] <= shd_q[i];
            end
        end

        if (i < N_CMP) begin : g_cmp_out
            assign cmp_act[i] = act_q[i];
        end
    end

    assign per_act = act_q[N_CMP];

endmodule

// File: rtl/pwm_match_bank.sv
// Module: pwm_match_bank
// One equality comparator per compare register, qualified by the count step.
// Assumes: tick is low whenever the timer is stopped.
module pwm_match_bank #(
    parameter int CNT_W = 16,
    parameter int N_CMP = 4
) (
    input  logic                        tick,
    input  logic [CNT_W-1:0]            count,
    input  logic [N_CMP-1:0][CNT_W-1:0] cmp_act,
    output logic [N_CMP-1:0]            match
);

    for (genvar i = 0; i < N_CMP; i++) begin : g_cmp
        // Pulse when this compare value equals the count on a step.
        assign match[i] = tick && (count == cmp_act[i]);
    end

endmodule

// File: rtl/pwm_period_timer.sv
// Module: pwm_period_timer (top)
// Up-counting PWM period timer with double-buffered period and compare
// registers, a register read/write port and a divided count enable.
// Assumes: register reads are combinational; writes take effect at the clock.
module pwm_period_timer #(
    parameter int CNT_W   = 16,
    parameter int N_CMP   = 4,
    parameter int PM_REGS = 2,
    parameter int DIV_W   = 2,
    parameter int ADDR_W  = $clog2(N_CMP + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic [DIV_W-1:0]  div_sel_i,
    input  logic              power_mode_i,
    input  logic [N_CMP-1:0]  buf_en_i,
    input  logic              wr_en_i,
    input  logic [1:0]        wr_size_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [CNT_W-1:0]  wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [CNT_W-1:0]  rd_data_o,
    output logic [CNT_W-1:0]  count_o,
    output logic [N_CMP-1:0]  match_o,
    output logic              period_match_o
);

    logic                        tick;
    logic                        wrap;
    logic [CNT_W-1:0]            per_act;
    logic [N_CMP-1:0][CNT_W-1:0] cmp_act;

    pwm_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run_i),
        .div_sel (div_sel_i),
        .tick    (tick)
    );

    pwm_up_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .period (per_act),
        .count  (count_o),
        .wrap   (wrap)
    );

    pwm_shadow_regs #(
        .CNT_W   (CNT_W),
        .N_CMP   (N_CMP),
        .PM_REGS (PM_REGS),
        .ADDR_W  (ADDR_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run_i),
        .power_mode (power_mode_i),
        .buf_en     (buf_en_i),
        .wr_en      (wr_en_i),
        .wr_size    (wr_size_i),
        .wr_addr    (wr_addr_i),
        .wr_data    (wr_data_i),
        .load       (wrap),
        .cmp_act    (cmp_act),
        .per_act    (per_act)
    );

    pwm_match_bank #(.CNT_W(CNT_W), .N_CMP(N_CMP)) u_match (
        .tick    (tick),
        .count   (count_o),
        .cmp_act (cmp_act),
        .match   (match_o)
    );

    assign period_match_o = wrap;

    // Return the active value of the addressed register, zero if unmapped.
    always_comb begin
        rd_data_o = '0;
        if (rd_addr_i == ADDR_W'(N_CMP)) begin
            rd_data_o = per_act;
        end
        for (int i = 0; i < N_CMP; i++) begin
            if (rd_addr_i == ADDR_W'(i)) begin
                rd_data_o = cmp_act[i];
            end
        end
    end

endmodule

// File: rtl/pwm_period_timer_chk.sv
// Module: pwm_period_timer_chk
// Property checker for pwm_period_timer, attached with bind below.
// Assumes: it observes the top ports and the active register copies.
module pwm_period_timer_chk #(
    parameter int CNT_W = 16,
    parameter int N_CMP = 4
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        run_i,
    input logic                        power_mode_i,
    input logic                        wr_en_i,
    input logic [1:0]                  wr_size_i,
    input logic [CNT_W-1:0]            count_o,
    input logic [N_CMP-1:0]            match_o,
    input logic                        period_match_o,
    input logic [CNT_W-1:0]            per_act,
    input logic [N_CMP-1:0][CNT_W-1:0] cmp_act
);

    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        period_match_o |=> (count_o == '0)); // R1

    AST_STOP_HOLDS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> $stable(count_o)); // R3

    AST_NO_MATCH_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |-> (match_o == '0)); // R2

    AST_PERIOD_HELD_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !period_match_o) |=> $stable(per_act)); // R6

    AST_PM_CMP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && power_mode_i && !period_match_o) |=> ($stable(cmp_act[0]) && $stable(cmp_act[1]))); // R7

    AST_BYTE_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && wr_en_i && wr_size_i == 2'b00) |=> ($stable(per_act) && $stable(cmp_act))); // R8

endmodule

bind pwm_period_timer pwm_period_timer_chk #(.CNT_W(CNT_W), .N_CMP(N_CMP)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .run_i          (run_i),
    .power_mode_i   (power_mode_i),
    .wr_en_i        (wr_en_i),
    .wr_size_i      (wr_size_i),
    .count_o        (count_o),
    .match_o        (match_o),
    .period_match_o (period_match_o),
    .per_act        (per_act),
    .cmp_act        (cmp_act)
);

// File: tb/pwm_period_timer_bench.sv
// Bench: directed scenarios for pwm_period_timer, one task each.
module pwm_period_timer_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        run_i;
    logic [1:0]  div_sel_i;
    logic        power_mode_i;
    logic [3:0]  buf_en_i;
    logic        wr_en_i;
    logic [1:0]  wr_size_i;
    logic [2:0]  wr_addr_i;
    logic [15:0] wr_data_i;
    logic [2:0]  rd_addr_i;
    logic [15:0] rd_data_o;
    logic [15:0] count_o;
    logic [3:0]  match_o;
    logic        period_match_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    pwm_period_timer u_pwm_period_timer (
        .clk            (clk),
        .rst_n          (rst_n),
        .run_i          (run_i),
        .div_sel_i      (div_sel_i),
        .power_mode_i   (power_mode_i),
        .buf_en_i       (buf_en_i),
        .wr_en_i        (wr_en_i),
        .wr_size_i      (wr_size_i),
        .wr_addr_i      (wr_addr_i),
        .wr_data_i      (wr_data_i),
        .rd_addr_i      (rd_addr_i),
        .rd_data_o      (rd_data_o),
        .count_o        (count_o),
        .match_o        (match_o),
        .period_match_o (period_match_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; run_i = 1'b0; div_sel_i = 2'd0; power_mode_i = 1'b0;
        buf_en_i = 4'd0; wr_en_i = 1'b0; wr_size_i = 2'b01; wr_addr_i = '0;
        wr_data_i = '0; rd_addr_i = '0;
        step(); step();
        rst_n = 1'b1;
        step();
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d, input logic [1:0] sz);
        wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d; wr_size_i = sz;
        step();
        wr_en_i = 1'b0;
    endtask

    task automatic rd_check(input logic [2:0] a, input int exp, input string req);
        rd_addr_i = a;
        #0.5;
        check(rd_data_o == exp, req, rd_data_o, exp);
    endtask

    task automatic t_reset();
        do_reset();
        check(count_o == 0, "R10 count", count_o, 0);
        check(match_o == 0, "R10 match", match_o, 0);
        for (int a = 0; a < 5; a++) rd_check(3'(a), 0, "R10 register");
        rd_check(3'd6, 0, "R4 unmapped");
    endtask

    task automatic t_direct_write();
        wr(3'd4, 16'd5, 2'b01);
        wr(3'd1, 16'd3, 2'b10);
        rd_check(3'd4, 5, "R3 period direct");
        rd_check(3'd1, 3, "R3 cmp1 direct");
        check(count_o == 0, "R3 count held", count_o, 0);
    endtask

    task automatic t_byte_reject();
        wr(3'd4, 16'd9, 2'b00);
        rd_check(3'd4, 5, "R8 byte write");
        wr(3'd1, 16'd9, 2'b00);
        rd_check(3'd1, 3, "R8 byte write cmp");
    endtask

    task automatic t_count_wrap();
        int pulses = 0;
        run_i = 1'b1;
        for (int k = 1; k <= 12; k++) begin
            step();
            check(count_o == k % 6, "R1 count", count_o, k % 6);
            check(match_o[1] == (count_o == 3), "R2 match cmp1", match_o[1], count_o == 3);
            if (match_o[1]) pulses++;
        end
        check(pulses == 2, "R2 pulses per two periods", pulses, 2);
        run_i = 1'b0;
        for (int k = 0; k < 3; k++) begin
            step();
            check(count_o == 0 && match_o == 0, "R2 R3 stopped", count_o, 0);
        end
    endtask

    task automatic t_buffered();
        buf_en_i = 4'b1000;
        run_i = 1'b1;
        wr(3'd4, 16'd7, 2'b01);
        wr(3'd3, 16'd4, 2'b01);
        wr(3'd2, 16'd2, 2'b01);
        rd_check(3'd4, 5, "R6 period held");
        rd_check(3'd3, 0, "R4 shadow hidden cmp3");
        rd_check(3'd2, 2, "R11 immediate cmp2");
        while (count_o != 5) step();
        step();
        check(count_o == 0, "R5 clear", count_o, 0);
        rd_check(3'd4, 7, "R5 period loaded");
        rd_check(3'd3, 4, "R5 cmp3 loaded");
        while (count_o != 7) step();
        step();
        check(count_o == 0, "R1 new period wrap", count_o, 0);
        run_i = 1'b0;
        step();
    endtask

    task automatic t_power_mode();
        power_mode_i = 1'b1;
        buf_en_i = 4'b0000;
        run_i = 1'b1;
        wr(3'd0, 16'd6, 2'b11);
        wr(3'd2, 16'd5, 2'b01);
        rd_check(3'd0, 0, "R7 cmp0 held");
        rd_check(3'd2, 5, "R11 cmp2 immediate");
        while (count_o != 7) step();
        step();
        rd_check(3'd0, 6, "R7 cmp0 loaded");
        run_i = 1'b0;
        power_mode_i = 1'b0;
        step();
    endtask

    task automatic t_prescale(input int sel);
        int n = 1 << sel;
        do_reset();
        wr(3'd4, 16'd2, 2'b01);
        wr(3'd1, 16'd1, 2'b01);
        div_sel_i = 2'(sel);
        run_i = 1'b1;
        for (int e = 1; e <= 3 * n + 2; e++) begin
            int ec = (e / n) % 3;
            bit em = ((e % n) == n - 1) && (ec == 1);
            step();
            check(count_o == ec, "R9 divided count", count_o, ec);
            check(match_o[1] == em, "R9 match on step", match_o[1], em);
        end
        run_i = 1'b0;
        step();
    endtask

    initial begin
        t_reset();
        t_direct_write();
        t_byte_reject();
        t_count_wrap();
        t_buffered();
        t_power_mode();
        t_prescale(2);
        t_prescale(1);
        t_prescale(3);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(5ns * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule